// File: doc/BRIEF.md
# Half-Duplex Shared-Bus Sample Port

This block joins a digital baseband controller to a converter front end over one 10-bit bidirectional bus. Transmit and receive bursts share the bus. Two enables decide the bus direction. The transmit enable lets the port capture words from the bus into the transmit path. The receive enable turns on the bus driver and streams converter samples out. The port drives separate output-data, output-enable and input-data signals, so the pad cell stays outside the block.

Each path has a shallow elastic FIFO. On the transmit side, the interpolator pulls words from the FIFO with a read strobe. On the receive side, converter samples fill the FIFO from the first active receive edge. The bus side starts draining it after a fixed latency. A static control set adjusts how the port behaves:

- the polarity of each enable;
- the sampling edge of each side;
- the number format of each side;
- a forced high-impedance state for the receive output;
- a drive-strength hint, passed straight through.

When a transmit burst ends, the port keeps feeding the interpolator zero words for a fixed number of cycles, so the interpolator is flushed. The bus is ignored during that time.

Top module: `hdx_port`

## Requirements
- R1: After reset, with both enables inactive, bus_oe is 0, dac_valid is 0, bus_out is 0 and all four FIFO flags are 0.
- R2: A word present on bus_in at a sampling edge where transmit is active, receive is inactive and mode_fd is low is queued in the transmit FIFO. With tx_rd high, the word is delivered on dac_data with dac_valid high after the next rising clock edge.
- R3: bus_oe is high exactly while mode_fd is low, receive is active and rx_tristate is 0. It falls in the same cycle that the receive enable deasserts, without waiting for a clock edge.
- R4: In a receive burst with adc_valid high, the sample accepted on the first active edge appears on bus_out right after the 6th active rising edge. One sample follows on each later edge. bus_out reads 0 before that point and whenever receive is inactive.
- R5: While receive is active, nothing from the bus is captured into the transmit path, even if the transmit enable is active.
- R6: After transmit capture stops, exactly 33 zero words are queued for the interpolator, one per clock, whatever bus_in holds. Each word is delivered on dac_data with dac_valid high.
- R7: tx_en_invert and rx_en_invert each make their enable active-low. A cleared bit means active-high.
- R8: With tx_twos clear (straight binary), the transmit path inverts bit 9 of the captured word; with it set, the word passes unchanged. rx_twos does the same for receive output. For example, bus word 0x000 gives dac word 0x200.
- R9: With tx_fall_edge set, bus_in and both enables are sampled on the falling clock edge before the rising edge that queues the word. With rx_fall_edge set, bus_out changes on the falling edge.
- R10: With mode_fd high, the port never drives the bus (bus_oe 0) and captures nothing.
- R11: Flags are sticky until reset. tx_ovf sets when a word arrives while the 5-deep transmit FIFO is full and not read. tx_unf sets on a tx_rd while the FIFO is empty. rx_unf sets when the bus side must drain an empty receive FIFO. rx_ovf sets when a sample arrives at a full receive FIFO that is not being drained.
- R12: low_drive always equals the drv_low input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock shared by the port, transmit and receive sides |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_fd | input | 1 | High selects the full-duplex placeholder; low selects half-duplex |
| tx_enable | input | 1 | Transmit enable pin, polarity per tx_en_invert |
| rx_enable | input | 1 | Receive enable pin, polarity per rx_en_invert |
| bus_in | input | 10 | Value read from the shared bus pads |
| bus_out | output | 10 | Value to drive onto the shared bus |
| bus_oe | output | 1 | Pad output enable for the shared bus |
| tx_en_invert | input | 1 | Transmit enable is active-low |
| tx_fall_edge | input | 1 | Transmit side samples on the falling edge |
| tx_twos | input | 1 | Transmit bus words are twos complement |
| rx_tristate | input | 1 | Forces the bus driver off |
| rx_en_invert | input | 1 | Receive enable is active-low |
| rx_fall_edge | input | 1 | Receive output updates on the falling edge |
| rx_twos | input | 1 | Receive bus words are twos complement |
| drv_low | input | 1 | Low drive-strength selection |
| low_drive | output | 1 | Drive-strength hint for the pads |
| tx_rd | input | 1 | Interpolator read request |
| dac_data | output | 10 | Transmit word to the interpolator, twos complement |
| dac_valid | output | 1 | dac_data holds a word read this cycle |
| adc_data | input | 10 | Converter sample, twos complement |
| adc_valid | input | 1 | adc_data is valid this cycle |
| tx_ovf | output | 1 | Sticky transmit FIFO overflow |
| tx_unf | output | 1 | Sticky transmit FIFO underflow |
| rx_ovf | output | 1 | Sticky receive FIFO overflow |
| rx_unf | output | 1 | Sticky receive FIFO underflow |

## Verification
The bench builds the port with its default parameters: 10-bit words, both FIFOs 5 deep, a 6-edge receive latency and a 33-word flush. With these values the whole flush window and the full receive latency fit into short bursts. Transmit overflow is reached after six unread words, and receive underflow after six edges with no converter data. Because the FIFO depth is one less than the receive latency, the receive FIFO is exactly full when draining starts. This exercises simultaneous push and pop on a full FIFO.

// File: rtl/hdx_pkg.sv
package hdx_pkg;
   // Fixed shape of the shared port
   localparam int HDX_WORD_W    = 10;
   localparam int HDX_FIFO_D    = 5;
   localparam int HDX_RX_LAT    = 6;
   localparam int HDX_FLUSH_LEN = 33;

   // Sign handling: straight binary differs from twos complement in the MSB only
   typedef enum logic {FMT_OFFSET = 1'b0, FMT_TWOS = 1'b1} num_fmt_e;
endpackage

// File: rtl/hdx_fifo.sv
module hdx_fifo #(
   parameter int W     = 10,
   parameter int DEPTH = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         push,
   input  logic [W-1:0] wdata,
   input  logic         pop,
   output logic [W-1:0] rdata,
   output logic         empty,
   output logic         ovf,
   output logic         unf
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);

   initial begin
      assert (DEPTH >= 2) else $error("hdx_fifo: DEPTH must be at least 2");
      assert (W >= 2) else $error("hdx_fifo: W must be at least 2");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] rd_ptr, wr_ptr, rd_nxt, wr_nxt;
   logic [CW-1:0] count;
   logic          full, do_push, do_pop;

   assign full    = (count == CW'(DEPTH));
   assign empty   = (count == '0);
   assign do_pop  = pop & ~empty;
   assign do_push = push & (~full | do_pop);
   assign rdata   = mem[rd_ptr];

   generate
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_wrap_pow2
         assign rd_nxt = rd_ptr + 1'b1;
         assign wr_nxt = wr_ptr + 1'b1;
      end else begin : g_wrap_cmp
         assign rd_nxt = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
         assign wr_nxt = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (do_push && !clr) mem[wr_ptr] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_ptr <= '0;
         wr_ptr <= '0;
         count  <= '0;
         ovf    <= 1'b0;
         unf    <= 1'b0;
      end else if (clr) begin
         rd_ptr <= '0;
         wr_ptr <= '0;
         count  <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_nxt;
         if (do_pop)  rd_ptr <= rd_nxt;
         case ({do_push, do_pop})
            2'b10:   count <= count + CW'(1);
            2'b01:   count <= count - CW'(1);
            default: count <= count;
         endcase
         if (push && !do_push) ovf <= 1'b1;
         if (pop && empty)     unf <= 1'b1;
      end
   end

   assert_count_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CW'(DEPTH));
   assert_ovf_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |=> ovf);
   assert_unf_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
      unf |=> unf);
   assert_full_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full && !pop && !clr) |=> (count == CW'(DEPTH)));
endmodule

// File: rtl/hdx_tx_path.sv
module hdx_tx_path #(
   parameter int W         = 10,
   parameter int DEPTH     = 5,
   parameter int FLUSH_LEN = 33
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         hd_mode,
   input  logic         tx_pin,
   input  logic         rx_pin,
   input  logic [W-1:0] bus_in,
   input  logic         tx_inv,
   input  logic         rx_inv,
   input  logic         fall_edge,
   input  logic         twos,
   input  logic         rd,
   output logic [W-1:0] dac_data,
   output logic         dac_valid,
   output logic         ovf,
   output logic         unf
);
   localparam int FCW = $clog2(FLUSH_LEN + 1);

   initial begin
      assert (FLUSH_LEN >= 1) else $error("hdx_tx_path: FLUSH_LEN must be positive");
   end

   logic [W-1:0]   n_bus, s_bus, wdata, rdata;
   logic           n_tx, n_rx, s_tx, s_rx;
   logic           cap, prev_cap, flush_go, push, empty, rx_on;
   logic [FCW-1:0] fcnt;

   // Falling-edge copy of the bus and enables
   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) begin
         n_bus <= '0;
         n_tx  <= 1'b0;
         n_rx  <= 1'b0;
      end else begin
         n_bus <= bus_in;
         n_tx  <= tx_pin;
         n_rx  <= rx_pin;
      end
   end

   assign s_bus    = fall_edge ? n_bus : bus_in;
   assign s_tx     = fall_edge ? n_tx  : tx_pin;
   assign s_rx     = fall_edge ? n_rx  : rx_pin;
   assign rx_on    = s_rx ^ rx_inv;
   assign cap      = hd_mode & (s_tx ^ tx_inv) & ~rx_on;
   assign flush_go = ~cap & (prev_cap | (fcnt != '0));
   assign push     = cap | flush_go;
   assign wdata    = cap ? (twos ? s_bus : {~s_bus[W-1], s_bus[W-2:0]}) : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_cap <= 1'b0;
         fcnt     <= '0;
      end else begin
         prev_cap <= cap;
         if (cap)                fcnt <= '0;
         else if (prev_cap)      fcnt <= FCW'(FLUSH_LEN - 1);
         else if (fcnt != '0)    fcnt <= fcnt - FCW'(1);
      end
   end

   hdx_fifo #(.W(W), .DEPTH(DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n), .clr(1'b0),
      .push(push), .wdata(wdata), .pop(rd),
      .rdata(rdata), .empty(empty), .ovf(ovf), .unf(unf)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dac_data  <= '0;
         dac_valid <= 1'b0;
      end else begin
         dac_valid <= rd & ~empty;
         if (rd && !empty) dac_data <= rdata;
      end
   end

   assert_flush_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !cap) |-> (wdata == '0));
   assert_flush_starts_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (prev_cap && !cap) |-> push);
   assert_no_loopback_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rx_on |-> !(push && wdata != '0));
endmodule

// File: rtl/hdx_rx_path.sv
module hdx_rx_path #(
   parameter int W     = 10,
   parameter int DEPTH = 5,
   parameter int LAT   = 6
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         active,
   input  logic         fall_edge,
   input  logic         twos,
   input  logic [W-1:0] adc_data,
   input  logic         adc_valid,
   output logic [W-1:0] bus_word,
   output logic         ovf,
   output logic         unf
);
   localparam int LW = $clog2(LAT + 1);

   initial begin
      assert (LAT >= 2) else $error("hdx_rx_path: LAT must be at least 2");
   end

   logic [LW-1:0] lcnt;
   logic [W-1:0]  rdata, pos_q, neg_q;
   logic          pop, empty;

   assign pop = active & (lcnt >= LW'(LAT - 1));

   hdx_fifo #(.W(W), .DEPTH(DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n), .clr(~active),
      .push(active & adc_valid), .wdata(adc_data), .pop(pop),
      .rdata(rdata), .empty(empty), .ovf(ovf), .unf(unf)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lcnt  <= '0;
         pos_q <= '0;
      end else if (!active) begin
         lcnt  <= '0;
         pos_q <= '0;
      end else begin
         if (lcnt != LW'(LAT)) lcnt <= lcnt + LW'(1);
         if (pop && !empty)
            pos_q <= twos ? rdata : {~rdata[W-1], rdata[W-2:0]};
      end
   end

   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) neg_q <= '0;
      else        neg_q <= pos_q;
   end

   assign bus_word = fall_edge ? neg_q : pos_q;

   assert_burst_starts_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(active) |-> empty);
   assert_idle_output_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !active |=> (pos_q == '0));
endmodule

// File: rtl/hdx_port.sv
module hdx_port #(
   parameter int W         = hdx_pkg::HDX_WORD_W,
   parameter int TX_DEPTH  = hdx_pkg::HDX_FIFO_D,
   parameter int RX_DEPTH  = hdx_pkg::HDX_FIFO_D,
   parameter int RX_LAT    = hdx_pkg::HDX_RX_LAT,
   parameter int FLUSH_LEN = hdx_pkg::HDX_FLUSH_LEN
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         mode_fd,
   input  logic         tx_enable,
   input  logic         rx_enable,
   input  logic [W-1:0] bus_in,
   output logic [W-1:0] bus_out,
   output logic         bus_oe,
   input  logic         tx_en_invert,
   input  logic         tx_fall_edge,
   input  logic         tx_twos,
   input  logic         rx_tristate,
   input  logic         rx_en_invert,
   input  logic         rx_fall_edge,
   input  logic         rx_twos,
   input  logic         drv_low,
   output logic         low_drive,
   input  logic         tx_rd,
   output logic [W-1:0] dac_data,
   output logic         dac_valid,
   input  logic [W-1:0] adc_data,
   input  logic         adc_valid,
   output logic         tx_ovf,
   output logic         tx_unf,
   output logic         rx_ovf,
   output logic         rx_unf
);
   initial begin
      assert (RX_LAT >= RX_DEPTH) else $error("hdx_port: RX_LAT below RX_DEPTH starves no one but wastes depth");
   end

   logic hd_mode, rx_active;

   assign hd_mode   = ~mode_fd;
   assign rx_active = hd_mode & (rx_enable ^ rx_en_invert);
   assign bus_oe    = rx_active & ~rx_tristate;
   assign low_drive = drv_low;

   hdx_tx_path #(.W(W), .DEPTH(TX_DEPTH), .FLUSH_LEN(FLUSH_LEN)) u_tx (
      .clk(clk), .rst_n(rst_n), .hd_mode(hd_mode),
      .tx_pin(tx_enable), .rx_pin(rx_enable), .bus_in(bus_in),
      .tx_inv(tx_en_invert), .rx_inv(rx_en_invert),
      .fall_edge(tx_fall_edge), .twos(tx_twos), .rd(tx_rd),
      .dac_data(dac_data), .dac_valid(dac_valid), .ovf(tx_ovf), .unf(tx_unf)
   );

   hdx_rx_path #(.W(W), .DEPTH(RX_DEPTH), .LAT(RX_LAT)) u_rx (
      .clk(clk), .rst_n(rst_n), .active(rx_active),
      .fall_edge(rx_fall_edge), .twos(rx_twos),
      .adc_data(adc_data), .adc_valid(adc_valid),
      .bus_word(bus_out), .ovf(rx_ovf), .unf(rx_unf)
   );

   assert_fd_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      mode_fd |-> !bus_oe);
   assert_tristate_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rx_tristate |-> !bus_oe);
endmodule

// File: tb/hdx_port_tb.sv
module hdx_port_tb;
   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic       rst_n = 1'b0, mode_fd = 1'b0, tx_enable = 1'b0, rx_enable = 1'b0;
   logic [9:0] bus_in = '0, adc_data = '0;
   logic       tx_en_invert = 0, tx_fall_edge = 0, tx_twos = 0;
   logic       rx_tristate = 0, rx_en_invert = 0, rx_fall_edge = 0, rx_twos = 0, drv_low = 0;
   logic       tx_rd = 1'b0, adc_valid = 1'b0;
   logic [9:0] bus_out, dac_data;
   logic       bus_oe, low_drive, dac_valid, tx_ovf, tx_unf, rx_ovf, rx_unf;

   hdx_port u_dut (
      .clk(clk), .rst_n(rst_n), .mode_fd(mode_fd), .tx_enable(tx_enable), .rx_enable(rx_enable),
      .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe),
      .tx_en_invert(tx_en_invert), .tx_fall_edge(tx_fall_edge), .tx_twos(tx_twos),
      .rx_tristate(rx_tristate), .rx_en_invert(rx_en_invert), .rx_fall_edge(rx_fall_edge),
      .rx_twos(rx_twos), .drv_low(drv_low), .low_drive(low_drive), .tx_rd(tx_rd),
      .dac_data(dac_data), .dac_valid(dac_valid), .adc_data(adc_data), .adc_valid(adc_valid),
      .tx_ovf(tx_ovf), .tx_unf(tx_unf), .rx_ovf(rx_ovf), .rx_unf(rx_unf)
   );

   int total = 0, fails = 0;
   bit run_cmp = 0;

   task automatic chk(string tag, int act, int exp);
      total++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #5;
   endtask

   // Behavioural reference
   logic [9:0] txq[$], rxq[$];
   logic [9:0] m_dac = '0, m_pos = '0, m_neg = '0, nb = '0;
   logic       m_dv = 0, m_tovf = 0, m_tunf = 0, m_rovf = 0, m_runf = 0, m_prev = 0;
   logic       ntx = 0, nrx = 0;
   int         m_f = 0, m_lc = 0;

   always @(negedge clk) begin
      nb = bus_in; ntx = tx_enable; nrx = rx_enable;
      m_neg = m_pos;
   end

   always @(posedge clk) begin
      if (!rst_n) begin
         txq.delete(); rxq.delete();
         m_dac = '0; m_pos = '0; m_dv = 0; m_tovf = 0; m_tunf = 0;
         m_rovf = 0; m_runf = 0; m_prev = 0; m_f = 0; m_lc = 0;
      end else begin
         logic [9:0] sb;
         logic ste, sre, cap, push, act;
         logic [9:0] w;
         sb  = tx_fall_edge ? nb  : bus_in;
         ste = tx_fall_edge ? ntx : tx_enable;
         sre = tx_fall_edge ? nrx : rx_enable;
         cap = !mode_fd && (ste ^ tx_en_invert) && !(sre ^ rx_en_invert);
         if (tx_rd) begin
            if (txq.size() > 0) begin m_dac = txq.pop_front(); m_dv = 1; end
            else begin m_dv = 0; m_tunf = 1; end
         end else m_dv = 0;
         push = 0; w = '0;
         if (cap) begin push = 1; w = tx_twos ? sb : sb ^ 10'h200; m_f = 0; end
         else if (m_prev) begin push = 1; m_f = 32; end
         else if (m_f > 0) begin push = 1; m_f--; end
         if (push) begin
            if (txq.size() < 5) txq.push_back(w); else m_tovf = 1;
         end
         m_prev = cap;
         act = !mode_fd && (rx_enable ^ rx_en_invert);
         if (!act) begin rxq.delete(); m_lc = 0; m_pos = '0; end
         else begin
            if (m_lc >= 5) begin
               if (rxq.size() > 0) begin
                  logic [9:0] h;
                  h = rxq.pop_front();
                  m_pos = rx_twos ? h : h ^ 10'h200;
               end else m_runf = 1;
            end
            if (adc_valid) begin
               if (rxq.size() < 5) rxq.push_back(adc_data); else m_rovf = 1;
            end
            if (m_lc != 6) m_lc++;
         end
      end
   end

   always @(posedge clk) begin
      if (run_cmp) begin
         #15;
         chk("R2 dac_valid", dac_valid, m_dv);
         chk("R2 dac_data", dac_data, m_dac);
         chk("R4 bus_out", bus_out, rx_fall_edge ? m_neg : m_pos);
         chk("R3 bus_oe", bus_oe, !mode_fd && (rx_enable ^ rx_en_invert) && !rx_tristate);
         chk("R11 flags", {tx_ovf, tx_unf, rx_ovf, rx_unf}, {m_tovf, m_tunf, m_rovf, m_runf});
         chk("R12 low_drive", low_drive, drv_low);
      end
   end

   task automatic summary();
      $display("  %0d/%0d checks passed", total - fails, total);
      $finish;
   endtask

   initial begin
      #4_000_000;
      total++; fails++;
      $display("FAIL watchdog expired");
      summary();
   end

   int cnt;

   initial begin
      step(); step(); step();
      rst_n = 1'b1;
      #1;
      // R1 reset state
      chk("R1 bus_oe", bus_oe, 0);
      chk("R1 dac_valid", dac_valid, 0);
      chk("R1 bus_out", bus_out, 0);
      chk("R1 flags", {tx_ovf, tx_unf, rx_ovf, rx_unf}, 0);
      run_cmp = 1;
      step();

      // R2/R8: straight-binary transmit burst
      tx_rd = 1; tx_enable = 1; bus_in = 10'h000;
      step(); bus_in = 10'h001;
      step(); #1;
      chk("R8 offset conversion", dac_data, 10'h200);
      chk("R2 first word valid", dac_valid, 1);
      #4 tx_enable = 0; bus_in = 10'h3AA;
      // R6: flush count
      cnt = 0;
      for (int k = 0; k < 40; k++) begin
         step(); #1;
         if (dac_valid && dac_data == 10'h000) cnt++;
         #4 bus_in = 10'(k * 37);
      end
      chk("R6 flush zero words", cnt, 33);

      // R4/R5: receive burst with transmit enable also high
      rx_enable = 1; tx_enable = 1; bus_in = 10'h155; adc_valid = 1; adc_data = 10'd100;
      cnt = 0;
      for (int k = 1; k <= 8; k++) begin
         step();
         adc_data = 10'(100 + k);
         #1;
         if (dac_valid) cnt++;
         if (k == 5) chk("R4 before latency", bus_out, 0);
         if (k == 6) chk("R4 latency six", bus_out, 10'd100 ^ 10'h200);
         if (k == 7) chk("R4 next sample", bus_out, 10'd101 ^ 10'h200);
         chk("R3 driving", bus_oe, 1);
         #4;
      end
      chk("R5 no loopback", cnt, 0);
      rx_enable = 0; tx_enable = 0; adc_valid = 0;
      #1 chk("R3 release immediate", bus_oe, 0);
      rx_tristate = 1; rx_enable = 1;
      #1 chk("R3 forced tristate", bus_oe, 0);
      step(); rx_enable = 0; rx_tristate = 0;
      step();

      // R7/R8: inverted enables, twos complement
      tx_en_invert = 1; rx_en_invert = 1; tx_twos = 1;
      tx_enable = 0; rx_enable = 1; bus_in = 10'h005;
      #1 chk("R7 inverted rx idle", bus_oe, 0);
      step(); bus_in = 10'h006;
      step(); #1;
      chk("R7 inverted capture", dac_valid, 1);
      chk("R8 twos passthrough", dac_data, 10'h005);
      #4 tx_enable = 1;
      for (int k = 0; k < 40; k++) step();
      tx_en_invert = 0; rx_en_invert = 0; tx_twos = 0; tx_enable = 0; rx_enable = 0;
      step();

      // R9: falling-edge sampling
      tx_fall_edge = 1; tx_enable = 1; bus_in = 10'h011;
      #10 bus_in = 10'h022;
      step();
      step(); #1;
      chk("R9 falling edge sample", dac_data, 10'h011 ^ 10'h200);
      #4 tx_enable = 0;
      for (int k = 0; k < 40; k++) step();
      tx_fall_edge = 0;
      rx_fall_edge = 1; rx_enable = 1; adc_valid = 1; adc_data = 10'h0F0;
      for (int k = 0; k < 6; k++) step();
      #1 chk("R9 rx falling not yet", bus_out, 0);
      #9; #3 chk("R9 rx falling updated", bus_out, 10'h0F0 ^ 10'h200);
      step(); rx_enable = 0; adc_valid = 0; rx_fall_edge = 0;
      step();

      // R11: overflow and underflow
      tx_rd = 0; tx_enable = 1;
      for (int k = 0; k < 7; k++) begin bus_in = 10'(k); step(); end
      #1 chk("R11 tx overflow", tx_ovf, 1);
      #4 tx_enable = 0; tx_rd = 1;
      for (int k = 0; k < 45; k++) step();
      chk("R11 tx underflow", tx_unf, 1);
      rx_enable = 1; adc_valid = 0;
      for (int k = 0; k < 7; k++) step();
      #1 chk("R11 rx underflow", rx_unf, 1);
      chk("R11 rx no overflow", rx_ovf, 0);
      #4 rx_enable = 0;
      step();

      // R10: full-duplex placeholder stays quiet
      mode_fd = 1; tx_enable = 1; rx_enable = 1; bus_in = 10'h2A5;
      cnt = 0;
      for (int k = 0; k < 5; k++) begin
         step(); #1;
         if (dac_valid) cnt++;
         chk("R10 no drive", bus_oe, 0);
         #4;
      end
      chk("R10 no capture", cnt, 0);
      mode_fd = 0; tx_enable = 0; rx_enable = 0;
      step();

      // R12
      drv_low = 1;
      #1 chk("R12 passthrough", low_drive, 1);
      step(); step();
      run_cmp = 0;
      #20;
      summary();
   end
endmodule